// File: doc/BRIEF.md
# Stereo PCM Serial Output Formatter

This block feeds an external stereo DAC. It takes one 16-bit left sample and one 16-bit right sample per frame and shifts both out, most significant bit first, on a single data line. Alongside the data it produces three clocks: a master clock, a bit clock and a word-select clock. All three come from one free-running counter that advances on a system clock enable, so their phases relative to each other never drift.

The enable `ce_i` marks half periods of the master clock, so it runs at 768 times the sample rate. One master-clock period is two enable ticks. One bit-clock period is 12 master-clock periods. One frame (one word-select period) is 32 bit-clock periods: one 16-bit slot while word-select is low, and one 16-bit slot while it is high.

A format byte picks one of eight serial variants from three bits:
- bit 2 selects the standard one-bit-delayed framing (I2S) or plain alignment;
- bit 1 selects which channel goes in the low word-select slot;
- bit 0 selects the bit-clock polarity.

Two mute controls and a de-emphasis flag are also provided. The mute output is active low. Muting forces the data line to zero. The de-emphasis flag is passed through to a pin.

Samples arrive through a valid/ready handshake into a one-pair holding register. That pair is taken into the shifter at each frame start.

Top module: `pcm_serial_fmt`

## Requirements
- R1: Counting enable ticks from reset, with t taken modulo 768:
  - `mclk_o` equals bit 0 of (t mod 24);
  - `lrck_o` is 0 during bit periods 0 to 15 of a frame and 1 during periods 16 to 31;
  - a bit period is 24 enable ticks;
  - outputs change only in a clock cycle in which `ce_i` was high.
- R2: The format byte is loaded only at a frame boundary, that is, on the enable tick that ends bit period 31.
  - It is accepted only when bits 7:3 equal 00000 or 10000.
  - Its bits 2, 1 and 0 become i2s, pl and pb.
  - Any other byte is ignored, and the previous format stays in force.
  - After reset the format is all zeros.
- R3: With i2s=1, data lags word-select by one bit period. Bit period 0 of a frame carries the LSB of the high word-select slot of the previous frame (zero for the first frame after reset).
- R4: With pl=0, the low word-select slot carries the left sample and the high slot the right sample. With pl=1 the two are swapped.
- R5: With pb=0, `bclk_o` is low for the first 12 enable ticks of each bit period and high for the last 12, so data changes on a falling edge. With pb=1 the bit clock is inverted.
- R6: Within a slot, the sample is sent MSB first, one bit per bit period.
- R7: `mute_n_o` is the inverse of `mute_req_i`, registered on every clock.
  - After reset, `mute_n_o` is 0 (muted).
  - While `mute_n_o` is 0, `sdata_o` is 0.
- R8: `deemph_o` follows `deemph_req_i` one clock later, and is 0 after reset.
- R9: Handshake and sample timing:
  - `s_ready_o` is 1 while the holding register is empty.
  - A pair offered with `s_valid_i` high while `s_ready_o` is high is stored.
  - The stored pair is moved into the shifter at the next frame boundary, which frees the holding register.
  - If no pair is held at a boundary, the next frame sends zeros.
- R10: After reset, all of the following hold: `mclk_o`, `bclk_o`, `lrck_o`, `sdata_o`, `mute_n_o` and `deemph_o` are 0, and `s_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Half-master-clock enable (768 fs) |
| fmt_i | input | 8 | Format byte {7:3 prefix, i2s, pl, pb} |
| mute_req_i | input | 1 | Mute request, active high |
| deemph_req_i | input | 1 | De-emphasis request |
| s_valid_i | input | 1 | Sample pair valid |
| s_left_i | input | 16 | Left sample |
| s_right_i | input | 16 | Right sample |
| s_ready_o | output | 1 | Holding register empty |
| mclk_o | output | 1 | Master clock, 384 fs |
| bclk_o | output | 1 | Bit clock, 32 fs |
| lrck_o | output | 1 | Word-select clock, fs |
| sdata_o | output | 1 | Serial data |
| mute_n_o | output | 1 | Mute output, active low |
| deemph_o | output | 1 | De-emphasis output |

## Verification
The sample stream uses left and right words with different MSB and LSB values. Because of this, a channel swap, a bit-order reversal or a missing one-bit delay each shows up as a different data pattern.

The format is walked through plain, delayed, swapped, inverted and all-bits-set settings, including the form with bit 7 set. Two prefixes that must be rejected are then offered while a non-default format is active, which shows whether the old format was kept.

Stopping the feed exposes the underflow zeros. Muting in the middle of a frame checks the forced-zero data and the one-clock latency of the mute and de-emphasis outputs.

// File: rtl/pcm_serial_fmt.sv
module pcm_serial_fmt #(
  parameter int SAMPLE_W      = 16,
  parameter int MCLK_PER_BCLK = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce_i,
  input  logic [7:0]          fmt_i,
  input  logic                mute_req_i,
  input  logic                deemph_req_i,
  input  logic                s_valid_i,
  input  logic [SAMPLE_W-1:0] s_left_i,
  input  logic [SAMPLE_W-1:0] s_right_i,
  output logic                s_ready_o,
  output logic                mclk_o,
  output logic                bclk_o,
  output logic                lrck_o,
  output logic                sdata_o,
  output logic                mute_n_o,
  output logic                deemph_o
);
  localparam int HALVES = 2 * MCLK_PER_BCLK;
  localparam int BITS   = 2 * SAMPLE_W;
  localparam int HW     = $clog2(HALVES);
  localparam int BW     = $clog2(BITS);
  localparam int SW     = $clog2(SAMPLE_W);

  logic [HW-1:0]       half_q;
  logic [BW-1:0]       bit_q;
  logic                i2s_q, pl_q, pb_q;
  logic [SAMPLE_W-1:0] act_l, act_r, pend_l, pend_r;
  logic                pend_q, prev_lsb_q, mute_q, deem_q;

  logic last_half, frame_end, fmt_ok, take;
  assign last_half = (half_q == HW'(HALVES - 1));
  assign frame_end = ce_i && last_half && (bit_q == BW'(BITS - 1));
  assign fmt_ok    = (fmt_i[7:3] == 5'b00000) || (fmt_i[7:3] == 5'b10000);
  assign take      = s_valid_i && !pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
      bit_q  <= '0;
    end else if (ce_i) begin
      if (last_half) begin
        half_q <= '0;
        bit_q  <= (bit_q == BW'(BITS - 1)) ? '0 : bit_q + 1'b1;
      end else begin
        half_q <= half_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i2s_q      <= 1'b0;
      pl_q       <= 1'b0;
      pb_q       <= 1'b0;
      act_l      <= '0;
      act_r      <= '0;
      prev_lsb_q <= 1'b0;
    end else if (frame_end) begin
      prev_lsb_q <= pl_q ? act_l[0] : act_r[0];
      act_l      <= pend_q ? pend_l : '0;
      act_r      <= pend_q ? pend_r : '0;
      if (fmt_ok) {i2s_q, pl_q, pb_q} <= fmt_i[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pend_l <= '0;
      pend_r <= '0;
    end else if (take) begin
      pend_q <= 1'b1;
      pend_l <= s_left_i;
      pend_r <= s_right_i;
    end else if (frame_end) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mute_q <= 1'b1;
      deem_q <= 1'b0;
    end else begin
      mute_q <= mute_req_i;
      deem_q <= deemph_req_i;
    end
  end

  logic [BW-1:0]       eidx;
  logic [SW-1:0]       pos;
  logic [SAMPLE_W-1:0] word;
  logic                bit_v;

  always_comb begin
    eidx = bit_q;
    if (i2s_q) eidx = (bit_q == '0) ? BW'(BITS - 1) : bit_q - 1'b1;
    pos   = SW'(32'(eidx) % SAMPLE_W);
    word  = ((eidx >= BW'(SAMPLE_W)) ^ pl_q) ? act_r : act_l;
    bit_v = word[SW'(SAMPLE_W - 1) - pos];
    if (i2s_q && bit_q == '0) bit_v = prev_lsb_q;
  end

  assign mclk_o    = half_q[0];
  assign bclk_o    = (half_q >= HW'(HALVES / 2)) ^ pb_q;
  assign lrck_o    = (bit_q >= BW'(SAMPLE_W));
  assign sdata_o   = !mute_q && bit_v;
  assign mute_n_o  = !mute_q;
  assign deemph_o  = deem_q;
  assign s_ready_o = !pend_q;

  a_r1_mclk_follows_ce: assert property (@(posedge clk) disable iff (!rst_n)
    ce_i |=> (mclk_o != $past(mclk_o)));
  a_r1_quiet_without_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_i |=> ($stable(bclk_o) && $stable(lrck_o) && $stable(mclk_o)));
  a_r2_format_held: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable({i2s_q, pl_q, pb_q}));
  a_r7_mute_zeroes_data: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_n_o |-> !sdata_o);
  a_r8_deemph_latency: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (deemph_o == $past(deemph_req_i)));
  a_r9_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid_i && s_ready_o) |=> !s_ready_o);
endmodule

// File: tb/pcm_serial_fmt_tb.sv
module pcm_serial_fmt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b0;
  logic [7:0]  fmt = 8'h00;
  logic        mute_req = 1'b1;
  logic        deem_req = 1'b0;
  logic        feed_en = 1'b0;
  logic        s_valid;
  logic [15:0] s_left, s_right;
  logic        s_ready, mclk, bclk, lrck, sdata, mute_n, deemph;

  int seq = 0;
  int checks = 0;
  int fails = 0;
  bit checking = 1'b0;

  always #10 clk = ~clk;

  assign s_valid = feed_en;
  assign s_left  = 16'(seq * 40503 + 32769);
  assign s_right = 16'(~(seq * 12345)) ^ 16'h0001;

  pcm_serial_fmt dut_i (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .fmt_i(fmt),
    .mute_req_i(mute_req), .deemph_req_i(deem_req),
    .s_valid_i(s_valid), .s_left_i(s_left), .s_right_i(s_right),
    .s_ready_o(s_ready), .mclk_o(mclk), .bclk_o(bclk), .lrck_o(lrck),
    .sdata_o(sdata), .mute_n_o(mute_n), .deemph_o(deemph)
  );

  always @(negedge clk) ce = ~ce;

  // reference model
  int          t = 0;
  logic [15:0] ql[$], qr[$];
  logic [15:0] al = 0, ar = 0;
  bit          prev = 0, i2s = 0, pl = 0, pb = 0, mute = 1, deem = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      t = 0; ql.delete(); qr.delete(); al = 0; ar = 0;
      prev = 0; i2s = 0; pl = 0; pb = 0; mute = 1; deem = 0;
    end else begin
      bit acc;
      acc = s_valid && (ql.size() == 0);
      mute = mute_req;
      deem = deem_req;
      if (ce) begin
        if (t == 767) begin
          prev = pl ? al[0] : ar[0];
          if (ql.size() != 0) begin al = ql.pop_front(); ar = qr.pop_front(); end
          else begin al = 0; ar = 0; end
          if (fmt[7:3] == 5'b00000 || fmt[7:3] == 5'b10000) begin
            i2s = fmt[2]; pl = fmt[1]; pb = fmt[0];
          end
        end
        t = (t + 1) % 768;
      end
      if (acc) begin
        ql.push_back(s_left); qr.push_back(s_right);
        seq <= seq + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at t=%0d: actual %b expected %b", tag, t, act, exp);
    end
  endtask

  always @(negedge clk) if (checking) begin
    int h, b, e;
    logic [15:0] w;
    logic eb;
    h = t % 24; b = t / 24;
    e = i2s ? (b + 31) % 32 : b;
    w = (((e >= 16) ? 1 : 0) ^ pl) ? ar : al;
    eb = (i2s && b == 0) ? prev : w[15 - (e % 16)];
    chk("R1 mclk", mclk, 1'(h % 2));
    chk("R5 R2 bclk", bclk, 1'((h >= 12) ^ pb));
    chk("R1 lrck", lrck, 1'(b >= 16));
    chk("R6 R3 R4 sdata", sdata, mute ? 1'b0 : eb);
    chk("R7 mute_n", mute_n, !mute);
    chk("R8 deemph", deemph, deem);
    chk("R9 ready", s_ready, ql.size() == 0);
  end

  task automatic frames(input int n);
    repeat (n * 1536) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 mclk", mclk, 1'b0);
    chk("R10 bclk", bclk, 1'b0);
    chk("R10 lrck", lrck, 1'b0);
    chk("R10 sdata", sdata, 1'b0);
    chk("R10 mute_n", mute_n, 1'b0);
    chk("R10 deemph", deemph, 1'b0);
    chk("R10 ready", s_ready, 1'b1);
    rst_n = 1'b1;
    checking = 1'b1;
    feed_en = 1'b1;
    frames(1);
    mute_req = 1'b0;
    frames(2);
    fmt = 8'h04; frames(2);             // R3 delayed framing
    fmt = 8'h02; frames(2);             // R4 swapped slots
    fmt = 8'h01; frames(2);             // R5 inverted bit clock
    fmt = 8'h87; deem_req = 1'b1; frames(2);
    fmt = 8'h08; frames(1);             // R2 rejected prefix, 0x87 stays
    fmt = 8'h40; frames(1);             // R2 rejected prefix
    fmt = 8'h06; frames(1);
    feed_en = 1'b0; frames(2);          // R9 underflow sends zeros
    feed_en = 1'b1; fmt = 8'h00;
    repeat (700) @(negedge clk);
    mute_req = 1'b1; deem_req = 1'b0;   // R7 mute mid-frame
    repeat (900) @(negedge clk);
    mute_req = 1'b0; frames(1);
    checking = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule